// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Divider Loader

This block takes a three-wire serial stream (a shift clock, a data line and a load strobe) and turns it into the divide settings of a frequency synthesizer. Bits enter a shift register on rising edges of the shift clock, most significant bit first. The last bit shifted is a control bit. While the load strobe is high, the shift register contents are copied into one of two latch sets, and the control bit picks which one. One set holds a 14-bit reference division count and a prescaler modulus select. The other holds a 7-bit swallow count and an 11-bit main count. All three serial inputs are oversampled by the block's own clock through a synchronizer chain, so the port can be driven from a slow, unrelated source.

The block also contains the reference divider. It divides the block clock by the latched reference count and gives a one-cycle pulse each period. On a board the load strobe input is pulled up, so an unconnected strobe reads as high. With the strobe held high the selected latch tracks the shift register on every cycle.

Top module: `synth_serial_loader`

## Requirements
- R1: A bit is taken into the shift register only on a rising edge of `ser_clk`. Changes of `ser_data` while `ser_clk` is high have no effect. Bits are sent most significant first.
- R2: A word whose last bit (shift register bit 0) is 1 writes the reference set. Register bits 14..1 hold the reference count, and bit 15 holds the prescaler select. Any higher bits are ignored.
- R3: A word whose last bit is 0 writes the divider set. Register bits 7..1 hold the swallow count, and bits 18..8 hold the main count.
- R4: While `ser_load` is low, all latched outputs hold, even when further bits are shifted in.
- R5: A reference word with a count below 3 is ignored entirely, and neither the count nor the prescaler select changes. A count of exactly 3 is accepted.
- R6: `presc_sel` is 0 for the 128/129 modulus and 1 for the 64/65 modulus. It takes the value of the reference word's top bit.
- R7: `fr_pulse` is high for one clock cycle in every `ref_count` cycles of `clk`.
- R8: After reset, `ref_count` is 3 and `presc_sel`, `swallow_count` and `main_count` are 0.
- R9: A reference write leaves the divider set unchanged, and a divider write leaves the reference set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the clock that the reference divider divides |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, sampled on rising edges |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe; high copies the word into the selected latch set |
| ref_count | output | 14 | Latched reference division count |
| presc_sel | output | 1 | Prescaler modulus select: 0 = 128/129, 1 = 64/65 |
| swallow_count | output | 7 | Latched swallow count |
| main_count | output | 11 | Latched main count |
| fr_pulse | output | 1 | Reference divider output pulse |

## Verification
The bench builds the block with its default parameters: 14/7/11-bit fields, two synchronizer stages and a minimum reference count of 3. With these values the full 16383 reference count and the all-ones divider fields can be tested in a short run. The minimum-count boundary at 2 and 3 lies within the same run, as do the shortest divider period and a ref word sent with extra leading bits. The data line is toggled while the shift clock is high in every bit, so only values taken at the rising edge can produce the expected fields.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
   typedef enum logic {
      PRESC_DIV128 = 1'b0,
      PRESC_DIV64  = 1'b1
   } presc_mode_e;

   localparam int SYNC_MAX = 8;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
   parameter int SR_W   = 19,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ser_clk,
   input  logic            ser_data,
   output logic [SR_W-1:0] word
);
   logic sclk_s, sdat_s, sclk_d, rise;

   sl_sync #(.STAGES(STAGES)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
   sl_sync #(.STAGES(STAGES)) i_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (rise) word <= {word[SR_W-2:0], sdat_s};
   end
endmodule

// File: rtl/sl_latches.sv
module sl_latches
   import synth_loader_pkg::*;
#(
   parameter int REF_W   = 14,
   parameter int SWAL_W  = 7,
   parameter int MAIN_W  = 11,
   parameter int SR_W    = 19,
   parameter int REF_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_s,
   input  logic [SR_W-1:0]   word,
   output logic [REF_W-1:0]  ref_q,
   output presc_mode_e       presc_q,
   output logic [SWAL_W-1:0] swal_q,
   output logic [MAIN_W-1:0] main_q
);
   localparam logic [REF_W-1:0] MIN_V = REF_W'(REF_MIN);
   localparam int SWAL_LO = 1;
   localparam int MAIN_LO = SWAL_LO + SWAL_W;
   localparam int PSEL_B  = REF_W + 1;

   logic              sel_ref;
   logic [REF_W-1:0]  ref_fld;
   logic [SWAL_W-1:0] swal_fld;
   logic [MAIN_W-1:0] main_fld;
   logic              ref_ok;

   assign sel_ref  = word[0];
   assign ref_fld  = word[REF_W:1];
   assign swal_fld = word[MAIN_LO-1:SWAL_LO];
   assign main_fld = word[MAIN_LO+MAIN_W-1:MAIN_LO];
   assign ref_ok   = (ref_fld >= MIN_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= MIN_V;
         presc_q <= PRESC_DIV128;
      end else if (load_s && sel_ref && ref_ok) begin
         ref_q   <= ref_fld;
         presc_q <= presc_mode_e'(word[PSEL_B]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swal_q <= '0;
         main_q <= '0;
      end else if (load_s && !sel_ref) begin
         swal_q <= swal_fld;
         main_q <= main_fld;
      end
   end
endmodule

// File: rtl/sl_ref_div.sv
module sl_ref_div #(
   parameter int REF_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] div_val,
   output logic             fr
);
   logic [REF_W-1:0] cnt;
   logic             term;

   assign term = (cnt >= div_val - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         fr  <= 1'b0;
      end else begin
         cnt <= term ? '0 : cnt + 1'b1;
         fr  <= term;
      end
   end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
   import synth_loader_pkg::*;
#(
   parameter int REF_W       = 14,
   parameter int SWAL_W      = 7,
   parameter int MAIN_W      = 11,
   parameter int SYNC_STAGES = 2,
   parameter int REF_MIN     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_load,
   output logic [REF_W-1:0]  ref_count,
   output logic              presc_sel,
   output logic [SWAL_W-1:0] swallow_count,
   output logic [MAIN_W-1:0] main_count,
   output logic              fr_pulse
);
   localparam int REF_WORD = REF_W + 2;
   localparam int DIV_WORD = SWAL_W + MAIN_W + 1;
   localparam int SR_W     = (REF_WORD > DIV_WORD) ? REF_WORD : DIV_WORD;

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > SYNC_MAX) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
      if (REF_MIN < 2 || REF_MIN >= (1 << REF_W)) begin : g_bad_min
         $error("REF_MIN must be at least 2 and fit in REF_W bits");
      end
      if (SWAL_W < 1 || MAIN_W < 1 || REF_W < 2) begin : g_bad_width
         $error("field widths too small");
      end
   endgenerate

   logic [SR_W-1:0] word;
   logic            load_s;
   presc_mode_e     presc_q;

   sl_shifter #(.SR_W(SR_W), .STAGES(SYNC_STAGES)) i_shift (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .word(word));

   sl_sync #(.STAGES(SYNC_STAGES)) i_sync_load (
      .clk(clk), .rst_n(rst_n), .d(ser_load), .q(load_s));

   sl_latches #(
      .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
      .SR_W(SR_W), .REF_MIN(REF_MIN)
   ) i_latch (
      .clk(clk), .rst_n(rst_n), .load_s(load_s), .word(word),
      .ref_q(ref_count), .presc_q(presc_q),
      .swal_q(swallow_count), .main_q(main_count));

   assign presc_sel = presc_q;

   sl_ref_div #(.REF_W(REF_W)) i_ref_div (
      .clk(clk), .rst_n(rst_n), .div_val(ref_count), .fr(fr_pulse));
endmodule

// File: rtl/sl_checker.sv
module sl_checker #(
   parameter int REF_W       = 14,
   parameter int SWAL_W      = 7,
   parameter int MAIN_W      = 11,
   parameter int SYNC_STAGES = 2,
   parameter int REF_MIN     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_clk,
   input logic              ser_data,
   input logic              ser_load,
   input logic [REF_W-1:0]  ref_count,
   input logic              presc_sel,
   input logic [SWAL_W-1:0] swallow_count,
   input logic [MAIN_W-1:0] main_count,
   input logic              fr_pulse
);
   localparam logic [REF_W-1:0] MIN_V = REF_W'(REF_MIN);
   localparam logic [3:0] QUIET_N = 4'(SYNC_STAGES + 1);

   logic [3:0] low_cnt;
   logic       ser_in_seen;

   assign ser_in_seen = ser_clk | ser_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= '0;
      else if (ser_load)       low_cnt <= '0;
      else if (low_cnt != 4'hF) low_cnt <= low_cnt + 1'b1;
   end

   AST_REF_ABOVE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ref_count >= MIN_V); // R5

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt >= QUIET_N) |=> ($stable(ref_count) && $stable(presc_sel) &&
                                $stable(swallow_count) && $stable(main_count))); // R4

   AST_FR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fr_pulse |=> !fr_pulse); // R7

   AST_OUTPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({ref_count, presc_sel, swallow_count, main_count, fr_pulse})); // R8

   AST_INPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({ser_in_seen, ser_load})); // R1
endmodule

bind synth_serial_loader sl_checker #(
   .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
   .SYNC_STAGES(SYNC_STAGES), .REF_MIN(REF_MIN)
) i_sl_checker (.*);

// File: tb/test_synth_serial_loader.sv
module test_synth_serial_loader;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [13:0] ref_count;
   logic        presc_sel;
   logic [6:0]  swallow_count;
   logic [10:0] main_count;
   logic        fr_pulse;

   synth_serial_loader i_synth_serial_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .ref_count(ref_count), .presc_sel(presc_sel),
      .swallow_count(swallow_count), .main_count(main_count),
      .fr_pulse(fr_pulse));

   integer n_checks = 0, n_err = 0;
   string  cur_req = "R8";
   bit     quiet = 1'b0;
   bit     done = 1'b0;
   int     m_ref = 3, m_presc = 0, m_swal = 0, m_main = 0;
   int     since = 0, pulses = 0;

   task automatic chk(input string r, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   // per-clock comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (quiet) begin
            chk({cur_req, " ref_count"}, int'(ref_count), m_ref);
            chk({cur_req, " presc_sel"}, int'(presc_sel), m_presc);
            chk({cur_req, " swallow_count"}, int'(swallow_count), m_swal);
            chk({cur_req, " main_count"}, int'(main_count), m_main);
         end
         since++;
         if (fr_pulse) begin
            if (quiet && pulses >= 1) chk("R7 fr period", since, m_ref);
            if (quiet) pulses++;
            since = 0;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // R1: data flips while the shift clock is high
   task automatic shift_bit(input logic b);
      ser_data = b;
      ser_clk  = 1'b0;
      tick(4);
      ser_clk = 1'b1;
      tick(2);
      ser_data = ~b;
      tick(2);
      ser_clk = 1'b0;
   endtask

   task automatic send(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
      tick(4);
   endtask

   task automatic strobe();
      quiet = 1'b0;
      ser_load = 1'b1;
      tick(4);
      ser_load = 1'b0;
      tick(6);
   endtask

   task automatic settle();
      pulses = 0;
      quiet = 1'b1;
   endtask

   task automatic write_div(input int mn, input int sw);
      send({13'd0, mn[10:0], sw[6:0], 1'b0}, 19);
      strobe();
      m_main = mn; m_swal = sw;
      settle();
   endtask

   task automatic write_ref(input int cnt, input int ps, input int extra);
      send({14'd0, extra[1:0], ps[0], cnt[13:0], 1'b1}, 16 + 2 * (extra != 0 ? 1 : 0));
      strobe();
      if (cnt >= 3) begin m_ref = cnt; m_presc = ps; end
      settle();
   endtask

   task automatic wait_periods(input int k);
      wait (pulses >= k);
      tick(2);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(1);
      cur_req = "R8";
      chk("R8 reset ref_count", int'(ref_count), 3);
      chk("R8 reset presc_sel", int'(presc_sel), 0);
      chk("R8 reset swallow", int'(swallow_count), 0);
      chk("R8 reset main", int'(main_count), 0);
      settle();
      wait_periods(3);

      cur_req = "R1";
      write_div(11'h5A3, 7'h41);
      cur_req = "R3";
      chk("R3 main field", int'(main_count), 11'h5A3);
      chk("R3 swallow field", int'(swallow_count), 7'h41);

      cur_req = "R2";
      write_ref(1000, 1, 0);
      chk("R2 ref field", int'(ref_count), 1000);
      chk("R6 prescaler 64/65", int'(presc_sel), 1);
      chk("R9 divider kept after ref write", int'(main_count), 11'h5A3);
      wait_periods(2);

      cur_req = "R5";
      write_ref(2, 0, 0);
      chk("R5 count 2 ignored", int'(ref_count), 1000);
      chk("R5 presc kept on ignored word", int'(presc_sel), 1);
      write_ref(3, 0, 0);
      chk("R5 count 3 accepted", int'(ref_count), 3);
      chk("R6 prescaler 128/129", int'(presc_sel), 0);
      wait_periods(4);

      cur_req = "R4";
      send(32'h0005_5AA5, 19);
      send(32'h0000_0003, 16);
      chk("R4 hold without load", int'(ref_count), 3);

      cur_req = "R2";
      write_ref(16383, 1, 3);
      chk("R2 max ref with extra leading bits", int'(ref_count), 16383);
      wait_periods(2);

      cur_req = "R9";
      write_div(11'h7FF, 7'h7F);
      chk("R9 ref kept after divider write", int'(ref_count), 16383);
      chk("R3 all-ones main", int'(main_count), 11'h7FF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog (%s): actual hung, expected completion", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule